// File: doc/BRIEF.md
# Palette Pixel Path with Cursor Overlay

This block turns a stream of 8-bit colour indices into 24-bit RGB for a raster display. Each input pixel carries its raster column and row and the index fetched from video memory. The index is looked up in a 256-entry colour table. A 64x64 hardware pointer is then laid over the picture. Its shape is held as two-bit codes, and a code other than zero replaces the video colour with one of three pointer colours. A blanking control forces the whole picture to black.

All tables and controls are loaded through one write port. A two-bit select picks the target and an address picks the entry. The pixel path has two register stages. Stage one reads the tables and works out the pointer code. Stage two chooses between the pointer colour, the video colour and black. A valid flag travels with every pixel, and invalid slots leave the output at zero.

Top module: `pixpal_overlay`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and out_rgb is 0. All tables, the control bits and the pointer position are cleared, so a pixel sent right after reset comes out as 0.
- R2: out_valid equals pix_valid from two clock cycles earlier. out_rgb is 0 whenever out_valid is 0.
- R3: A write with wr_sel=0 stores wr_data into colour table entry wr_addr[7:0], with red in bits 23:16, green in 15:8 and blue in 7:0. A video pixel whose pointer code is 0 is output as the colour table entry selected by its index.
- R4: The pointer position is a 24-bit value: column in bits 23:12 and row in bits 11:0. A pixel is inside the pointer window only when position column <= x < column+64 and position row <= y < row+64, compared without wrap-around. Pixels outside the window, including the part of a window that would lie past coordinate 4095, use the colour table.
- R5: Shape memory holds 512 words of 16 bits and is written with wr_sel=2, wr_addr[8:0] and wr_data[15:0]. Inside the window, with row offset r and column offset c, the pixel uses word r*8 + c/8 and takes its code from bits [2*(c mod 8)+1 : 2*(c mod 8)].
- R6: Code 0 is transparent and shows the video colour. Code n (1 to 3) shows pointer colour entry n-1. Pointer colours are written with wr_sel=1, entry wr_addr[1:0], using the same RGB packing as R3.
- R7: When control bit 23 (pointer off) is 1, every pixel shows its colour table entry, even inside the window.
- R8: When control bit 10 (blank) is 1, every valid output pixel is 0, whatever the pointer shows.
- R9: A table, shape, position or control write affects pixels presented in later cycles. A pixel presented in the same cycle as the write still sees the old contents.
- R10: With wr_sel=3, wr_addr[0]=0 loads the control word and wr_addr[0]=1 loads the position from wr_data[23:0]. A pointer colour write to entry 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for tables and controls |
| wr_sel | input | 2 | Write target: 0 colour table, 1 pointer colours, 2 shape memory, 3 control/position |
| wr_addr | input | 9 | Entry address within the selected target |
| wr_data | input | 24 | Write data (RGB, shape word, control word or position) |
| pix_valid | input | 1 | Input pixel present |
| pix_x | input | 12 | Raster column of the input pixel |
| pix_y | input | 12 | Raster row of the input pixel |
| pix_index | input | 8 | Colour index from video memory |
| out_valid | output | 1 | Output pixel present, two cycles after input |
| out_rgb | output | 24 | Output colour, red in 23:16, green in 15:8, blue in 7:0 |

## Verification
The hardest situation to reach is a pointer window that runs past the last coordinate. Only a window placed near 4095 shows whether the window comparison wraps into columns or rows near zero. The stimulus parks the pointer at column 4090 and row 4070 and sends random pixels on both sides of that edge and near coordinate zero. Same-cycle write and read collisions are equally hard to reach at random. They are driven on purpose against each table and against the control word, with the pixel in the same cycle expected to see the old value and the next pixel the new one.

// File: rtl/pixpal_pkg.sv
// Shared definitions for the palette pixel path: write target encoding,
// control bit positions and the colour type. Assumes 8-bit RGB channels.
package pixpal_pkg;
    typedef logic [23:0] rgb_t;

    typedef enum logic [1:0] {
        SEL_CLUT    = 2'd0,
        SEL_CURPAL  = 2'd1,
        SEL_PATTERN = 2'd2,
        SEL_CTRL    = 2'd3
    } wsel_e;

    localparam int BLANK_BIT = 10;
    localparam int NOCUR_BIT = 23;
    localparam int CUR_COLOURS = 3;
endpackage

// File: rtl/pixpal_cfg.sv
// Control word, pointer position and pointer colour registers.
// Assumes the caller has already qualified the write strobe per target.
module pixpal_cfg
    import pixpal_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_we,
    input  logic                      cpal_we,
    input  logic [1:0]                wr_sub,
    input  logic [2*COORD_W-1:0]      wr_data,
    output logic                      blank,
    output logic                      cur_off,
    output logic [COORD_W-1:0]        cur_x,
    output logic [COORD_W-1:0]        cur_y,
    output logic [CUR_COLOURS-1:0][23:0] cpal
);
    // Control and position registers, selected by the low address bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank   <= 1'b0;
            cur_off <= 1'b0;
            cur_x   <= '0;
            cur_y   <= '0;
        end else if (ctrl_we) begin
            if (wr_sub[0]) begin
                cur_x <= wr_data[2*COORD_W-1:COORD_W];
                cur_y <= wr_data[COORD_W-1:0];
            end else begin
                blank   <= wr_data[BLANK_BIT];
                cur_off <= wr_data[NOCUR_BIT];
            end
        end
    end

    // One register per pointer colour; an address past the last entry is dropped.
    for (genvar g = 0; g < CUR_COLOURS; g++) begin : g_cpal
        always_ff @(posedge clk) begin
            if (!rst_n)
                cpal[g] <= '0;
            else if (cpal_we && wr_sub == 2'(g))
                cpal[g] <= wr_data[23:0];
        end
    end
endmodule

// File: rtl/pixpal_lut.sv
// Colour table with a registered read port. A write and a read of the same
// entry in one cycle return the old value. Assumes one write per cycle.
module pixpal_lut
    import pixpal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rgb_t             wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output rgb_t             rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t mem [DEPTH];

    // Table storage plus the stage-one read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_rgb <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_rgb;
            rd_rgb <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/pixpal_cursor.sv
// Pointer window test, shape memory and code extraction. It registers the
// code and the chosen pointer colour as stage one. Assumes CUR_DIM and
// CODES_PER_WORD are powers of two.
module pixpal_cursor
    import pixpal_pkg::*;
#(
    parameter int COORD_W        = 12,
    parameter int CUR_DIM        = 64,
    parameter int CODES_PER_WORD = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pat_we,
    input  logic [$clog2(CUR_DIM*CUR_DIM/CODES_PER_WORD)-1:0] pat_addr,
    input  logic [2*CODES_PER_WORD-1:0]  pat_data,
    input  logic [COORD_W-1:0]           pix_x,
    input  logic [COORD_W-1:0]           pix_y,
    input  logic                         cur_off,
    input  logic [COORD_W-1:0]           cur_x,
    input  logic [COORD_W-1:0]           cur_y,
    input  logic [CUR_COLOURS-1:0][23:0] cpal,
    output logic [1:0]                   s1_code,
    output rgb_t                         s1_cur_rgb
);
    localparam int PAT_W     = 2 * CODES_PER_WORD;
    localparam int PAT_WORDS = CUR_DIM * CUR_DIM / CODES_PER_WORD;
    localparam int PAT_AW    = $clog2(PAT_WORDS);
    localparam int OFF_W     = $clog2(CUR_DIM);
    localparam int SUB_W     = $clog2(CODES_PER_WORD);

    logic [PAT_W-1:0]   pat [PAT_WORDS];
    logic [COORD_W-1:0] dx_full, dy_full;
    logic               hit;
    logic [PAT_AW-1:0]  rd_addr;
    logic [PAT_W-1:0]   word;
    logic [1:0]         code;

    // Window test without wrap-around, then word and bit-pair selection.
    always_comb begin
        dx_full = pix_x - cur_x;
        dy_full = pix_y - cur_y;
        hit = (pix_x >= cur_x) && (dx_full < COORD_W'(CUR_DIM)) &&
              (pix_y >= cur_y) && (dy_full < COORD_W'(CUR_DIM));
        rd_addr = {dy_full[OFF_W-1:0], dx_full[OFF_W-1:SUB_W]};
        word = pat[rd_addr];
        code = word[{dx_full[SUB_W-1:0], 1'b0} +: 2];
    end

    // Shape memory writes; the read above sees the contents before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAT_WORDS; i++) pat[i] <= '0;
        end else if (pat_we) begin
            pat[pat_addr] <= pat_data;
        end
    end

    // Stage-one register of the effective code and its pointer colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_code    <= '0;
            s1_cur_rgb <= '0;
        end else if (hit && !cur_off && code != 2'd0) begin
            s1_code    <= code;
            s1_cur_rgb <= cpal[code - 2'd1];
        end else begin
            s1_code    <= '0;
            s1_cur_rgb <= '0;
        end
    end
endmodule

// File: rtl/pixpal_overlay.sv
// Top of the palette pixel path. Decodes the write port, runs the two-stage
// pipeline (table reads, then select/blank) and carries a valid flag.
// Assumes pixels arrive at most one per clock.
module pixpal_overlay
    import pixpal_pkg::*;
#(
    parameter int IDX_W          = 8,
    parameter int COORD_W        = 12,
    parameter int CUR_DIM        = 64,
    parameter int CODES_PER_WORD = 8,
    parameter int ADDR_W         = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [23:0]        wr_data,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [IDX_W-1:0]   pix_index,
    output logic               out_valid,
    output logic [23:0]        out_rgb
);
    localparam int PAT_AW = $clog2(CUR_DIM * CUR_DIM / CODES_PER_WORD);
    localparam int PAT_W  = 2 * CODES_PER_WORD;

    wsel_e sel;
    logic  lut_we, cpal_we, pat_we, ctrl_we;
    logic  blank, cur_off;
    logic [COORD_W-1:0] cur_x, cur_y;
    logic [CUR_COLOURS-1:0][23:0] cpal;
    rgb_t  s1_pal_rgb, s1_cur_rgb;
    logic [1:0] s1_code;
    logic  s1_valid, s1_blank;

    // Write strobe decode per target.
    always_comb begin
        sel     = wsel_e'(wr_sel);
        lut_we  = wr_en && (sel == SEL_CLUT);
        cpal_we = wr_en && (sel == SEL_CURPAL);
        pat_we  = wr_en && (sel == SEL_PATTERN);
        ctrl_we = wr_en && (sel == SEL_CTRL);
    end

    pixpal_cfg #(.COORD_W(COORD_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .cpal_we (cpal_we),
        .wr_sub  (wr_addr[1:0]),
        .wr_data (wr_data),
        .blank   (blank),
        .cur_off (cur_off),
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .cpal    (cpal)
    );

    pixpal_lut #(.IDX_W(IDX_W)) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lut_we),
        .wr_idx (wr_addr[IDX_W-1:0]),
        .wr_rgb (wr_data),
        .rd_idx (pix_index),
        .rd_rgb (s1_pal_rgb)
    );

    pixpal_cursor #(
        .COORD_W        (COORD_W),
        .CUR_DIM        (CUR_DIM),
        .CODES_PER_WORD (CODES_PER_WORD)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_we     (pat_we),
        .pat_addr   (wr_addr[PAT_AW-1:0]),
        .pat_data   (wr_data[PAT_W-1:0]),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .cur_off    (cur_off),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .cpal       (cpal),
        .s1_code    (s1_code),
        .s1_cur_rgb (s1_cur_rgb)
    );

    // Stage one: valid flag and blank control travel with the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_blank <= 1'b0;
        end else begin
            s1_valid <= pix_valid;
            s1_blank <= blank;
        end
    end

    // Stage two: blank first, then pointer colour, then video colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (!s1_valid || s1_blank)
                out_rgb <= '0;
            else if (s1_code != 2'd0)
                out_rgb <= s1_cur_rgb;
            else
                out_rgb <= s1_pal_rgb;
        end
    end
endmodule

// File: rtl/pixpal_overlay_chk.sv
// Assertion checker for the palette pixel path, attached by bind.
// Assumes the top's internal stage signals keep their names.
module pixpal_overlay_chk #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_y,
    input logic               out_valid,
    input logic [23:0]        out_rgb,
    input logic               s1_valid,
    input logic               s1_blank,
    input logic [1:0]         s1_code,
    input logic               cur_off,
    input logic [COORD_W-1:0] cur_y
);
    logic [1:0] since_rst;

    // Counts clock edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(pix_valid, 2)));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == 24'd0));

    p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_blank) |=> (out_rgb == 24'd0));

    p_pointer_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cur_off) |=> (s1_code == 2'd0));

    p_above_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (pix_y < cur_y)) |=> (s1_code == 2'd0));
endmodule

bind pixpal_overlay pixpal_overlay_chk #(.COORD_W(COORD_W)) u_chk (.*);

// File: tb/pixpal_overlay_test.sv
module pixpal_overlay_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [8:0]  wr_addr;
    logic [23:0] wr_data;
    logic        pix_valid;
    logic [11:0] pix_x, pix_y;
    logic [7:0]  pix_index;
    logic        out_valid;
    logic [23:0] out_rgb;

    pixpal_overlay uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_index(pix_index),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    logic [23:0] mpal [256];
    logic [23:0] mcpal [3];
    logic [15:0] mpat [512];
    logic        mblank, moff;
    logic [11:0] mcx, mcy;

    logic        e1_v, e2_v;
    logic [23:0] e1_rgb, e2_rgb;
    string       e1_tag, e2_tag;

    task automatic chk(input bit ok, input string tag, input logic [24:0] act, input logic [24:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_rgb(input logic [11:0] x, input logic [11:0] y, input logic [7:0] idx);
        logic [11:0] dx, dy;
        logic [15:0] w;
        logic [1:0]  c;
        if (mblank) return 24'd0;
        dx = x - mcx;
        dy = y - mcy;
        if (!moff && x >= mcx && dx < 12'd64 && y >= mcy && dy < 12'd64) begin
            w = mpat[int'(dy) * 8 + int'(dx) / 8];
            c = w[2 * (int'(dx) % 8) +: 2];
            if (c != 2'd0) return mcpal[int'(c) - 1];
        end
        return mpal[idx];
    endfunction

    // One cycle: check the output of two cycles ago, drive new inputs, update the model.
    task automatic step(input logic we, input logic [1:0] sel, input logic [8:0] a, input logic [23:0] d,
                        input logic pv, input logic [11:0] x, input logic [11:0] y, input logic [7:0] idx,
                        input string tag);
        if (e2_v)
            chk(out_valid === 1'b1 && out_rgb === e2_rgb, e2_tag, {out_valid, out_rgb}, {1'b1, e2_rgb});
        else
            chk(out_valid === 1'b0 && out_rgb === 24'd0, "R2", {out_valid, out_rgb}, 25'd0);
        e2_v = e1_v; e2_rgb = e1_rgb; e2_tag = e1_tag;
        e1_v = pv; e1_rgb = pv ? model_rgb(x, y, idx) : 24'd0; e1_tag = tag;
        wr_en = we; wr_sel = sel; wr_addr = a; wr_data = d;
        pix_valid = pv; pix_x = x; pix_y = y; pix_index = idx;
        if (we) begin
            case (sel)
                2'd0: mpal[a[7:0]] = d;
                2'd1: if (a[1:0] != 2'd3) mcpal[a[1:0]] = d;
                2'd2: mpat[a] = d[15:0];
                default: if (a[0]) begin mcx = d[23:12]; mcy = d[11:0]; end
                         else begin mblank = d[10]; moff = d[23]; end
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [8:0] a, input logic [23:0] d);
        step(1'b1, sel, a, d, 1'b0, 12'd0, 12'd0, 8'd0, "R2");
    endtask

    task automatic px(input logic [11:0] x, input logic [11:0] y, input logic [7:0] idx, input string tag);
        step(1'b0, 2'd0, 9'd0, 24'd0, 1'b1, x, y, idx, tag);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0;
        pix_valid = 0; pix_x = 0; pix_y = 0; pix_index = 0;
        for (int i = 0; i < 256; i++) mpal[i] = 0;
        for (int i = 0; i < 512; i++) mpat[i] = 0;
        for (int i = 0; i < 3; i++) mcpal[i] = 0;
        mblank = 0; moff = 0; mcx = 0; mcy = 0;
        e1_v = 0; e2_v = 0; e1_rgb = 0; e2_rgb = 0; e1_tag = "R2"; e2_tag = "R2";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_rgb === 24'd0, "R1", {out_valid, out_rgb}, 25'd0);
        px(12'd5, 12'd5, 8'd77, "R1");
        px(12'd300, 12'd9, 8'd200, "R1");

        // R3 colour table packing and lookup (pointer shape is all transparent)
        wr(2'd0, 9'h012, 24'hA1B2C3);
        px(12'd0, 12'd0, 8'h12, "R3");
        px(12'd500, 12'd400, 8'h12, "R3");

        // Random tables
        for (int i = 0; i < 256; i++) wr(2'd0, 9'(i), 24'($urandom));
        for (int i = 0; i < 3; i++) wr(2'd1, 9'(i), 24'($urandom));
        for (int i = 0; i < 512; i++) wr(2'd2, 9'(i), 24'($urandom));

        // R4 window bounds at column 100, row 200
        wr(2'd3, 9'd1, {12'd100, 12'd200});
        wr(2'd2, 9'd0, 24'h00FFFF);
        wr(2'd2, 9'd7 * 8 + 9'd7, 24'h00FFFF);
        wr(2'd2, 9'd63 * 8 + 9'd7, 24'h00FFFF);
        px(12'd100, 12'd200, 8'd3, "R4");
        px(12'd163, 12'd263, 8'd4, "R4");
        px(12'd164, 12'd200, 8'd5, "R4");
        px(12'd99, 12'd200, 8'd6, "R4");
        px(12'd100, 12'd199, 8'd7, "R4");
        px(12'd100, 12'd264, 8'd8, "R4");

        // R5 and R6: codes 0,1,2,3 in order along one word at row 3, word 2
        wr(2'd2, 9'd26, 24'h00E4E4);
        for (int c = 0; c < 8; c++) px(12'd116 + 12'(c), 12'd203, 8'(c + 40), c[1:0] == 2'd0 ? "R6" : "R5");

        // R4 window crossing the far edge
        wr(2'd3, 9'd1, {12'd4090, 12'd4070});
        for (int i = 0; i < 300; i++)
            px(12'd4080 + 12'($urandom_range(0, 15)), 12'd4060 + 12'($urandom_range(0, 35)), 8'($urandom), "R4");
        for (int i = 0; i < 60; i++)
            px(12'($urandom_range(0, 40)), 12'($urandom_range(0, 40)), 8'($urandom), "R4");

        // R7 pointer off
        wr(2'd3, 9'd1, {12'd100, 12'd200});
        wr(2'd3, 9'd0, 24'h800000);
        px(12'd100, 12'd200, 8'd3, "R7");
        for (int c = 0; c < 8; c++) px(12'd116 + 12'(c), 12'd203, 8'(c + 40), "R7");
        wr(2'd3, 9'd0, 24'h000000);

        // R8 blank wins over pointer and video
        wr(2'd3, 9'd0, 24'h000400);
        px(12'd100, 12'd200, 8'd3, "R8");
        px(12'd117, 12'd203, 8'd41, "R8");
        px(12'd900, 12'd10, 8'd9, "R8");
        wr(2'd3, 9'd0, 24'h000000);

        // R9 same-cycle write sees old, next pixel sees new
        step(1'b1, 2'd0, 9'd7, 24'h0F1E2D, 1'b1, 12'd900, 12'd10, 8'd7, "R9");
        px(12'd900, 12'd10, 8'd7, "R9");
        step(1'b1, 2'd1, 9'd0, 24'h123456, 1'b1, 12'd117, 12'd203, 8'd41, "R9");
        px(12'd117, 12'd203, 8'd41, "R9");
        step(1'b1, 2'd2, 9'd26, 24'h000000, 1'b1, 12'd118, 12'd203, 8'd42, "R9");
        px(12'd118, 12'd203, 8'd42, "R9");
        step(1'b1, 2'd3, 9'd0, 24'h000400, 1'b1, 12'd900, 12'd10, 8'd7, "R9");
        px(12'd900, 12'd10, 8'd7, "R9");
        step(1'b1, 2'd3, 9'd0, 24'h000000, 1'b1, 12'd900, 12'd10, 8'd7, "R9");
        px(12'd900, 12'd10, 8'd7, "R9");

        // R10 pointer colour entry 3 is not stored; shape restored with all codes
        wr(2'd2, 9'd26, 24'h00E4E4);
        wr(2'd1, 9'd3, 24'hDEAD00);
        for (int c = 1; c < 4; c++) px(12'd116 + 12'(c), 12'd203, 8'd1, "R10");

        // R6 random mix around the window with occasional writes
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0)
                step(1'b1, 2'($urandom_range(0, 2)), 9'($urandom), 24'($urandom), 1'($urandom),
                     mcx + 12'($urandom_range(0, 80)) - 12'd8, mcy + 12'($urandom_range(0, 80)) - 12'd8,
                     8'($urandom), "R9");
            else
                step(1'b0, 2'd0, 9'd0, 24'd0, 1'($urandom_range(0, 3) != 0),
                     mcx + 12'($urandom_range(0, 80)) - 12'd8, mcy + 12'($urandom_range(0, 80)) - 12'd8,
                     8'($urandom), "R6");
            if (i == 1500) wr(2'd3, 9'd1, {12'($urandom), 12'($urandom)});
        end

        step(1'b0, 2'd0, 9'd0, 24'd0, 1'b0, 12'd0, 12'd0, 8'd0, "R2");
        step(1'b0, 2'd0, 9'd0, 24'd0, 1'b0, 12'd0, 12'd0, 8'd0, "R2");
        step(1'b0, 2'd0, 9'd0, 24'd0, 1'b0, 12'd0, 12'd0, 8'd0, "R2");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule